// File: doc/BRIEF.md
# Dual-Length PRBS Built-In Self-Test

This block gives one line channel a built-in pattern test. A single enable bit starts both halves together. The transmit half runs a linear feedback shift register, and its output replaces the outgoing system data. The receive half runs a second register that first trains itself on the incoming bits. Once it has locked, it predicts every following bit and flags each bit that differs from its prediction. A line-mode select picks the pattern length. The short mode uses a 2^15-1 sequence, for the DS3 and STS-1 rates. The long mode uses a 2^23-1 sequence, for the E3 rate.

While the test runs, the channel is forced into single-rail operation and the transmit negative rail is held low. The receive violation output is taken over as a per-bit error strobe. Flagged errors also accumulate in a saturating counter. Reading the counter returns its value and clears it. When the block is disabled, every rail and violation signal passes straight through.

Top module: `prbs_bist`

## Requirements
- R1: With `bist_en`=0, `tx_pos_out`=`tx_pos_in`, `tx_neg_out`=`tx_neg_in`, `rx_lcv_out`=`rx_lcv_in` and `rail_dual_eff`=`rail_dual`. The generator is held at its all-ones seed and the checker is held in search.
- R2: The generator starts from an all-ones seed, so its first bit is 0, and it yields one bit per clock while enabled. With `mode_long`=0 each bit is b[n]=b[n-15]^b[n-14], which is x^15+x^14+1. With `mode_long`=1 each bit is b[n]=b[n-23]^b[n-18], which is x^23+x^18+1. The mode in effect is the one registered at the previous clock edge.
- R3: With `bist_en`=1, `tx_pos_out` carries the pattern bit and `tx_neg_out` is 0, whatever `tx_pos_in` and `tx_neg_in` are.
- R4: With `bist_en`=1, `rail_dual_eff` is 0, whatever `rail_dual` is.
- R5: In search, the checker shifts received bits into its register and compares each new bit with the tap prediction. After 32 consecutive matches, `locked` rises at the next clock edge. From then on, the register runs on its own predictions.
- R6: With `bist_en`=1, `rx_lcv_out` is 1 in exactly those cycles where the checker is locked and `rx_data_in` differs from the predicted bit. It is 0 during search.
- R7: While locked, the checker returns to search when the 8th flagged error arrives within one 64-bit window.
- R8: `cnt_rdata` shows the error count, which rises by one for each flagged error. It saturates at 2^CNT_W-1 (0xFFFF by default) instead of wrapping.
- R9: With `cnt_rd`=1, `cnt_rdata` shows the current count in that cycle. At the clock edge the count becomes 1 if an error is flagged in that same cycle, and 0 otherwise.
- R10: A change of `mode_long` while enabled reseeds the generator and sends the checker back to search at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_en | input | 1 | Runs the generator and the checker together |
| mode_long | input | 1 | 1 selects the 2^23-1 pattern, 0 selects the 2^15-1 pattern |
| rail_dual | input | 1 | Requested dual-rail mode |
| rail_dual_eff | output | 1 | Rail mode in effect |
| tx_pos_in | input | 1 | System transmit positive rail |
| tx_neg_in | input | 1 | System transmit negative rail |
| tx_pos_out | output | 1 | Transmit positive rail towards the line |
| tx_neg_out | output | 1 | Transmit negative rail towards the line |
| rx_data_in | input | 1 | Received data bit |
| rx_lcv_in | input | 1 | Received negative rail or violation flag |
| rx_lcv_out | output | 1 | Violation output, or error strobe while the test runs |
| locked | output | 1 | Checker is locked to the pattern |
| cnt_rd | input | 1 | Read strobe for the error counter |
| cnt_rdata | output | CNT_W | Error counter value |

## Verification
Two functions can fall in the same cycle: the read-and-clear of the counter and the counting of a newly flagged error. The bench provokes this by raising `cnt_rd` in the very cycle it flips a looped-back bit while the checker is locked. It then expects the count to restart at 1, not at 0. A second overlap is a mode change in a cycle where the checker is locked. There, the flag for that cycle must still be judged against the old taps, and the loss of lock must take effect at the following edge.

// File: rtl/prbs_bist_pkg.sv
package prbs_bist_pkg;

    localparam int LFSR_W = 23;

    typedef enum logic {
        CHK_SEARCH = 1'b0,
        CHK_LOCKED = 1'b1
    } chk_state_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_pair_t;

    // Next sequence bit from a history register whose bit 0 is the newest bit.
    function automatic logic tap_bit(input logic [LFSR_W-1:0] hist, input logic long_mode);
        return long_mode ? (hist[22] ^ hist[17]) : (hist[14] ^ hist[13]);
    endfunction

endpackage

// File: rtl/prbs_bist_gen.sv
module prbs_bist_gen
    import prbs_bist_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic mode_q,
    output logic pat_bit
);

    logic [LFSR_W-1:0] state;

    assign pat_bit = tap_bit(state, mode_q);

    always_ff @(posedge clk) begin
        if (rst || restart) state <= '1;
        else                state <= {state[LFSR_W-2:0], pat_bit};
    end

    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        !restart |=> state != '0); // R2

endmodule

// File: rtl/prbs_bist_chk.sv
module prbs_bist_chk
    import prbs_bist_pkg::*;
#(
    parameter int SYNC_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic enable,
    input  logic mode_q,
    input  logic rx_bit,
    output logic locked,
    output logic err
);

    localparam int RUN_W = $clog2(SYNC_RUN);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam int ERR_W = $clog2(LOSS_ERRS);

    chk_state_e        st;
    logic [LFSR_W-1:0] hist;
    logic [RUN_W-1:0]  run;
    logic [WIN_W-1:0]  win;
    logic [ERR_W-1:0]  errs;
    logic              pred;
    logic              mism;

    assign pred   = tap_bit(hist, mode_q);
    assign mism   = rx_bit != pred;
    assign locked = (st == CHK_LOCKED);
    assign err    = enable && locked && mism;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st   <= CHK_SEARCH;
            hist <= '0;
            run  <= '0;
            win  <= '0;
            errs <= '0;
        end else begin
            case (st)
                CHK_SEARCH: begin
                    hist <= {hist[LFSR_W-2:0], rx_bit};
                    if (mism) begin
                        run <= '0;
                    end else if (run == RUN_W'(SYNC_RUN - 1)) begin
                        st   <= CHK_LOCKED;
                        run  <= '0;
                        win  <= '0;
                        errs <= '0;
                    end else begin
                        run <= run + RUN_W'(1);
                    end
                end
                default: begin
                    hist <= {hist[LFSR_W-2:0], pred};
                    if (mism && errs == ERR_W'(LOSS_ERRS - 1)) begin
                        st  <= CHK_SEARCH;
                        run <= '0;
                    end else if (win == WIN_W'(WIN_LEN - 1)) begin
                        win  <= '0;
                        errs <= '0;
                    end else begin
                        win  <= win + WIN_W'(1);
                        errs <= errs + ERR_W'(mism);
                    end
                end
            endcase
        end
    end

    AST_RESTART_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        restart |=> !locked); // R10

    AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(!mism)); // R5

endmodule

// File: rtl/prbs_bist_cnt.sv
module prbs_bist_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                        cnt <= '0;
        else if (rd)                    cnt <= CNT_W'(inc);
        else if (inc && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end

    AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !rd) |=> cnt == CNT_MAX); // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!rd && inc && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_W'(1)); // R8

    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rd |=> cnt <= CNT_W'(1)); // R9

endmodule

// File: rtl/prbs_bist.sv
module prbs_bist
    import prbs_bist_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bist_en,
    input  logic             mode_long,
    input  logic             rail_dual,
    output logic             rail_dual_eff,
    input  logic             tx_pos_in,
    input  logic             tx_neg_in,
    output logic             tx_pos_out,
    output logic             tx_neg_out,
    input  logic             rx_data_in,
    input  logic             rx_lcv_in,
    output logic             rx_lcv_out,
    output logic             locked,
    input  logic             cnt_rd,
    output logic [CNT_W-1:0] cnt_rdata
);

    logic       mode_q;
    logic       restart;
    logic       pat_bit;
    logic       err;
    rail_pair_t tx_sys;
    rail_pair_t tx_line;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= mode_long;
    end

    assign restart = !bist_en || (mode_long != mode_q);

    prbs_bist_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .mode_q  (mode_q),
        .pat_bit (pat_bit)
    );

    prbs_bist_chk #(
        .SYNC_RUN  (SYNC_RUN),
        .WIN_LEN   (WIN_LEN),
        .LOSS_ERRS (LOSS_ERRS)
    ) u_chk (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .enable  (bist_en),
        .mode_q  (mode_q),
        .rx_bit  (rx_data_in),
        .locked  (locked),
        .err     (err)
    );

    prbs_bist_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .rd  (cnt_rd),
        .inc (err),
        .cnt (cnt_rdata)
    );

    always_comb begin
        tx_sys.pos = tx_pos_in;
        tx_sys.neg = tx_neg_in;
        if (bist_en) begin
            tx_line.pos = pat_bit;
            tx_line.neg = 1'b0;
        end else begin
            tx_line = tx_sys;
        end
    end

    assign tx_pos_out    = tx_line.pos;
    assign tx_neg_out    = tx_line.neg;
    assign rail_dual_eff = rail_dual && !bist_en;
    assign rx_lcv_out    = bist_en ? err : rx_lcv_in;

endmodule

// File: tb/prbs_bist_tb.sv
`timescale 1ns/1ps
module prbs_bist_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bist_en = 0, mode_long = 0, rail_dual = 0;
    logic tx_pos_in = 0, tx_neg_in = 0, rx_lcv_in = 0, cnt_rd = 0;
    logic loop = 1, inj = 0, ext = 0;
    logic rail_dual_eff, tx_pos_out, tx_neg_out, rx_lcv_out, locked;
    logic [15:0] cnt_rdata;
    logic s_rail, s_txp, s_txn, s_lcv, s_locked;
    logic [3:0] s_cnt;
    logic rx_data_in;

    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign rx_data_in = loop ? (tx_pos_out ^ inj) : ext;

    prbs_bist u_dut (
        .clk(clk), .rst(rst), .bist_en(bist_en), .mode_long(mode_long),
        .rail_dual(rail_dual), .rail_dual_eff(rail_dual_eff),
        .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in),
        .tx_pos_out(tx_pos_out), .tx_neg_out(tx_neg_out),
        .rx_data_in(rx_data_in), .rx_lcv_in(rx_lcv_in), .rx_lcv_out(rx_lcv_out),
        .locked(locked), .cnt_rd(cnt_rd), .cnt_rdata(cnt_rdata)
    );

    prbs_bist #(.CNT_W(4)) u_dut_small (
        .clk(clk), .rst(rst), .bist_en(bist_en), .mode_long(mode_long),
        .rail_dual(rail_dual), .rail_dual_eff(s_rail),
        .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in),
        .tx_pos_out(s_txp), .tx_neg_out(s_txn),
        .rx_data_in(rx_data_in), .rx_lcv_in(rx_lcv_in), .rx_lcv_out(s_lcv),
        .locked(s_locked), .cnt_rd(cnt_rd), .cnt_rdata(s_cnt)
    );

    // Reference model state
    bit g_hist[$];
    bit c_hist[$];
    bit m_mode_q = 0, c_lock = 0;
    int c_run = 0, c_win = 0, c_errs = 0, m_cnt = 0, m_cnt_s = 0;
    bit e_restart, e_pat, e_tx, e_rx, e_pred, e_mism, e_err;

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic seed_model();
        g_hist.delete();
        c_hist.delete();
        for (int i = 0; i < 23; i++) begin
            g_hist.push_back(1'b1);
            c_hist.push_back(1'b0);
        end
        c_lock = 0; c_run = 0; c_win = 0; c_errs = 0;
    endtask

    task automatic model_eval();
        e_restart = !bist_en || (mode_long != m_mode_q);
        e_pat  = m_mode_q ? (g_hist[22] ^ g_hist[17]) : (g_hist[14] ^ g_hist[13]);
        e_tx   = bist_en ? e_pat : tx_pos_in;
        e_rx   = loop ? (e_tx ^ inj) : ext;
        e_pred = m_mode_q ? (c_hist[22] ^ c_hist[17]) : (c_hist[14] ^ c_hist[13]);
        e_mism = e_rx != e_pred;
        e_err  = bist_en && c_lock && e_mism;
    endtask

    task automatic model_step();
        if (e_restart) begin
            seed_model();
        end else begin
            g_hist.push_front(e_pat);
            void'(g_hist.pop_back());
            if (!c_lock) begin
                c_hist.push_front(e_rx);
                void'(c_hist.pop_back());
                if (e_mism) c_run = 0;
                else if (c_run == 31) begin c_lock = 1; c_run = 0; c_win = 0; c_errs = 0; end
                else c_run++;
            end else begin
                c_hist.push_front(e_pred);
                void'(c_hist.pop_back());
                if (e_mism && c_errs == 7) begin c_lock = 0; c_run = 0; end
                else if (c_win == 63) begin c_win = 0; c_errs = 0; end
                else begin c_win++; c_errs += int'(e_mism); end
            end
        end
        m_mode_q = mode_long;
        if (cnt_rd) begin
            m_cnt = int'(e_err);
            m_cnt_s = int'(e_err);
        end else if (e_err) begin
            if (m_cnt < 65535) m_cnt++;
            if (m_cnt_s < 15) m_cnt_s++;
        end
    endtask

    // One clock: called just after a falling edge with inputs already set.
    task automatic cycle();
        tx_pos_in = 1'($urandom);
        tx_neg_in = 1'($urandom);
        rail_dual = 1'($urandom);
        rx_lcv_in = 1'($urandom);
        if (!loop) ext = 1'($urandom);
        #2;
        model_eval();
        check(bist_en ? "R3 R2 tx_pos" : "R1 tx_pos", tx_pos_out, e_tx);
        check(bist_en ? "R3 tx_neg" : "R1 tx_neg", tx_neg_out, bist_en ? 0 : tx_neg_in);
        check(bist_en ? "R4 rail" : "R1 rail", rail_dual_eff, bist_en ? 0 : rail_dual);
        check(bist_en ? "R6 err flag" : "R1 lcv", rx_lcv_out, bist_en ? e_err : rx_lcv_in);
        check("R5 locked", locked, c_lock);
        check("R8 count", cnt_rdata, m_cnt);
        check("R8 saturating count", s_cnt, m_cnt_s);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic error_bit();
        inj = 1; cycle(); inj = 0;
    endtask

    initial begin
        seed_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        check("R8 reset count", cnt_rdata, 0);
        check("R5 reset locked", locked, 0);

        // R1: pass-through while disabled
        run(20);

        // R2 R3 R5: short pattern, loopback, lock
        bist_en = 1; loop = 1;
        run(100);
        check("R5 lock short mode", locked, 1);

        // R6 R8: isolated errors
        for (int k = 0; k < 3; k++) begin error_bit(); run(10); end
        check("R8 three errors", cnt_rdata, 3);

        // R9: plain read, then read with a same-cycle error
        cnt_rd = 1; cycle(); cnt_rd = 0;
        check("R9 read clears", cnt_rdata, 0);
        run(5);
        error_bit(); run(3);
        cnt_rd = 1; inj = 1; cycle(); cnt_rd = 0; inj = 0;
        check("R9 read with same-cycle error", cnt_rdata, 1);

        // R7: eight errors in one window drop lock
        run(70);
        for (int k = 0; k < 8; k++) begin error_bit(); cycle(); end
        check("R7 lock lost", locked, 0);

        // R10 R2: relock, then switch to long mode while enabled
        run(100);
        check("R5 relock", locked, 1);
        mode_long = 1; cycle();
        check("R10 mode change unlocks", locked, 0);
        run(120);
        check("R5 lock long mode", locked, 1);

        // R8: saturation of the narrow counter
        cnt_rd = 1; cycle(); cnt_rd = 0;
        for (int k = 0; k < 20; k++) begin error_bit(); run(15); end
        check("R8 narrow counter saturated", s_cnt, 15);
        check("R8 wide counter", cnt_rdata, 20);

        // Noise on the receive side, then disable
        loop = 0;
        run(200);
        loop = 1; mode_long = 0;
        run(80);
        bist_en = 0;
        run(30);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule